// File: doc/BRIEF.md
# Shadowed Synchronous Time-of-Day Counter

This block keeps a free-running time-of-day value that is 96 bits wide. The value has three words: a sub-nanosecond fraction at the bottom, a low nanosecond word in the middle and a high nanosecond word at the top. On every clock the block adds a programmable 40-bit increment to this value. The increment is a nanosecond part of up to 8 bits joined to a 32-bit fraction. Software changes the counter only in two phases. First it writes shadow registers and a pending command code through a simple write port. Then a separate sync strobe, which can be shared by many instances, makes the command take effect on that clock edge. All timers that share the strobe therefore switch on the same cycle.

The commands are:
- load a new time
- load a new increment
- step the nanosecond value by a signed amount
- arm a step that waits until the low nanosecond word reaches a target
- capture the whole 96-bit value into a snapshot register, so it can be read coherently

Top module: `tod_sync_counter`

## Requirements
- R1: While reset is held low at a clock edge, the time output becomes 0, the snapshot becomes 0, the increment becomes 1 ns (a value of 1 shifted left by 32), and no command is pending.
- R2: At each edge with no time-writing command, the time output grows by the zero-extended 40-bit increment. The increment lands in the fraction word and carries through the low word into the high word, wrapping modulo 2^96.
- R3: A write with wr_en high stores wr_data into the register at wr_addr. The addresses are: 0 time-low shadow, 1 time-high shadow, 2 adjust-low shadow, 3 adjust-high shadow, 4 command (bits 2:0). The command codes are: 0 idle, 1 load time, 2 load increment, 3 adjust, 4 adjust-at-time, 5 read. A code of 6 or 7 is stored as idle, and a write to address 5, 6 or 7 is dropped. A pending command changes nothing until sync_exec is high.
- R4: Load time executes at the sync edge. The top two words take the time-high and time-low shadows, the fraction becomes 0, and no increment is added on that edge.
- R5: Load increment executes at the sync edge. The new increment is {adjust-high[7:0], adjust-low}. Time still advances by the old increment on that edge.
- R6: Adjust executes at the sync edge. The 64-bit nanosecond part gains the sign-extended adjust-high word, the fraction is unchanged, and no increment is added on that edge.
- R7: Read executes at the sync edge. The snapshot takes the time value that was present just before that edge, and the counter keeps counting. At all other edges the snapshot holds its value.
- R8: Each sync edge returns the pending command to idle, so a second strobe with no new command write changes nothing.
- R9: Adjust-at-time executes at the sync edge and arms a step. It stores the time-low shadow as the target and the adjust-high shadow as the amount. At the first later edge where the low nanosecond word is at or above the target (unsigned), the step is applied as in R6, and it is then disarmed.
- R10: A shadow or command write in the same cycle as sync_exec does not change the command that executes; that command uses the earlier shadow contents. The write itself is stored, and a command written on that edge stays pending.
- R11: On an edge where a command executes, an armed step that has reached its target is deferred. It is applied at the next edge that has no command and still meets its condition. A new adjust-at-time replaces the armed step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is one counter tick |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| sync_exec | input | 1 | Executes the pending command on this edge |
| time_o | output | 96 | Live time: {high ns, low ns, fraction} |
| snap_o | output | 96 | Time captured by the last read command |
| inc_o | output | 40 | Increment in use: {ns part, fraction} |

## Verification
Two events can fall on the same edge. The first is a shadow or command write arriving while sync_exec executes the previous command. The second is an armed step reaching its target on an edge where another command executes. The bench provokes the first by writing a new adjust amount, and later a new command code, in the very cycle the strobe is high. It provokes the second by arming a step whose target is already reached and then strobing a read on the next cycle. An arithmetic reference model runs alongside the design and is compared on every cycle. It shows that the executed step used the old amount, that the written value served the next command, and that the deferred step landed exactly one edge after the read.

// File: rtl/tod_pkg.sv
// Package: shared command codes, register addresses and the command decoder
// for the shadowed time-of-day counter.
package tod_pkg;

    localparam int ADDR_W = 3;

    // Command codes written into the command register.
    typedef enum logic [2:0] {
        CMD_IDLE      = 3'd0,
        CMD_LOAD_TIME = 3'd1,
        CMD_LOAD_INC  = 3'd2,
        CMD_ADJUST    = 3'd3,
        CMD_ADJ_AT    = 3'd4,
        CMD_READ      = 3'd5
    } tod_cmd_e;

    localparam logic [ADDR_W-1:0] A_SH_TIME_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_SH_TIME_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_SH_ADJ_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SH_ADJ_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMD        = 3'd4;

    // Maps a raw code to a legal command; anything undefined becomes idle.
    function automatic tod_cmd_e decode_cmd(input logic [2:0] raw);
        case (raw)
            3'd1:    return CMD_LOAD_TIME;
            3'd2:    return CMD_LOAD_INC;
            3'd3:    return CMD_ADJUST;
            3'd4:    return CMD_ADJ_AT;
            3'd5:    return CMD_READ;
            default: return CMD_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/tod_shadow_regs.sv
// Module: tod_shadow_regs
// Holds the four staging words and the pending command. The command returns
// to idle on every sync edge unless a new command is written on that edge.
// Assumes WORD_W >= 3 so that the command code fits in wr_data[2:0].
module tod_shadow_regs
    import tod_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sync_exec,
    output logic [WORD_W-1:0] sh_time_lo,
    output logic [WORD_W-1:0] sh_time_hi,
    output logic [WORD_W-1:0] sh_adj_lo,
    output logic [WORD_W-1:0] sh_adj_hi,
    output tod_cmd_e          cmd_o
);

    logic     cmd_wr;
    tod_cmd_e cmd_q;

    assign cmd_wr = wr_en && (wr_addr == A_CMD);
    assign cmd_o  = cmd_q;

    // Stores shadow words written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_time_lo <= '0;
            sh_time_hi <= '0;
            sh_adj_lo  <= '0;
            sh_adj_hi  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_SH_TIME_LO: sh_time_lo <= wr_data;
                A_SH_TIME_HI: sh_time_hi <= wr_data;
                A_SH_ADJ_LO:  sh_adj_lo  <= wr_data;
                A_SH_ADJ_HI:  sh_adj_hi  <= wr_data;
                default:      ;
            endcase
        end
    end

    // Pending command: a write wins, otherwise a sync edge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_IDLE;
        end else if (cmd_wr) begin
            cmd_q <= decode_cmd(wr_data[2:0]);
        end else if (sync_exec) begin
            cmd_q <= CMD_IDLE;
        end
    end

    // R8: a sync edge without a command write leaves nothing pending.
    a_r8_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_exec && !cmd_wr) |=> (cmd_q == CMD_IDLE));

    // R3: without a write or a sync the pending command is unchanged.
    a_r3_cmd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_exec && !cmd_wr) |=> $stable(cmd_q));

endmodule

// File: rtl/tod_time_core.sv
// Module: tod_time_core
// Time register, increment register and armed-step state. It applies the
// executed command in place of the normal tick where the command writes the
// time. Assumes INC_HI_W <= WORD_W.
module tod_time_core
    import tod_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int INC_HI_W     = 8,
    parameter int INC_RESET_NS = 1,
    localparam int INC_W  = WORD_W + INC_HI_W,
    localparam int TIME_W = 3 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_exec,
    input  tod_cmd_e          cmd_i,
    input  logic [WORD_W-1:0] sh_time_lo,
    input  logic [WORD_W-1:0] sh_time_hi,
    input  logic [WORD_W-1:0] sh_adj_lo,
    input  logic [WORD_W-1:0] sh_adj_hi,
    output logic [TIME_W-1:0] time_o,
    output logic [INC_W-1:0]  inc_o
);

    localparam int NS_W = 2 * WORD_W;
    localparam int PAD  = TIME_W - INC_W;
    localparam logic [INC_W-1:0] INC_RST =
        INC_W'(INC_RESET_NS) << WORD_W;

    logic [TIME_W-1:0] time_q, time_d, tick_val;
    logic [INC_W-1:0]  inc_q, inc_d;
    logic              armed_q, armed_d;
    logic [WORD_W-1:0] tgt_q, tgt_d, aadj_q, aadj_d;
    logic [NS_W-1:0]   ns_cur;
    logic              fire_hit, fire_now, time_cmd;
    tod_cmd_e          exec;

    assign time_o   = time_q;
    assign inc_o    = inc_q;
    assign ns_cur   = time_q[TIME_W-1:WORD_W];
    assign tick_val = time_q + {{PAD{1'b0}}, inc_q};
    assign fire_hit = armed_q && (time_q[NS_W-1:WORD_W] >= tgt_q);
    assign exec     = sync_exec ? cmd_i : CMD_IDLE;

    // Next-state selection: executed command, armed step, or normal tick.
    always_comb begin
        time_d   = tick_val;
        inc_d    = inc_q;
        armed_d  = armed_q;
        tgt_d    = tgt_q;
        aadj_d   = aadj_q;
        time_cmd = 1'b0;
        fire_now = 1'b0;
        case (exec)
            CMD_LOAD_TIME: begin
                time_d   = {sh_time_hi, sh_time_lo, {WORD_W{1'b0}}};
                time_cmd = 1'b1;
            end
            CMD_LOAD_INC: begin
                inc_d = {sh_adj_hi[INC_HI_W-1:0], sh_adj_lo};
            end
            CMD_ADJUST: begin
                time_d   = {ns_cur + {{WORD_W{sh_adj_hi[WORD_W-1]}}, sh_adj_hi},
                            time_q[WORD_W-1:0]};
                time_cmd = 1'b1;
            end
            CMD_ADJ_AT: begin
                armed_d = 1'b1;
                tgt_d   = sh_time_lo;
                aadj_d  = sh_adj_hi;
            end
            CMD_READ: ;
            default: begin
                if (fire_hit) begin
                    time_d   = {ns_cur + {{WORD_W{aadj_q[WORD_W-1]}}, aadj_q},
                                time_q[WORD_W-1:0]};
                    armed_d  = 1'b0;
                    time_cmd = 1'b1;
                    fire_now = 1'b1;
                end
            end
        endcase
    end

    // State registers for time, increment and the armed step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q  <= '0;
            inc_q   <= INC_RST;
            armed_q <= 1'b0;
            tgt_q   <= '0;
            aadj_q  <= '0;
        end else begin
            time_q  <= time_d;
            inc_q   <= inc_d;
            armed_q <= armed_d;
            tgt_q   <= tgt_d;
            aadj_q  <= aadj_d;
        end
    end

    // R2: edges without a time-writing command advance by the increment.
    a_r2_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !time_cmd |=> ((time_q - $past(time_q)) == {{PAD{1'b0}}, $past(inc_q)}));

    // R4: loading the time zeroes the fraction word.
    a_r4_frac_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_exec && cmd_i == CMD_LOAD_TIME) |=> (time_q[WORD_W-1:0] == '0));

    // R6: an adjust leaves the fraction word untouched.
    a_r6_frac_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_exec && cmd_i == CMD_ADJUST) |=>
        (time_q[WORD_W-1:0] == $past(time_q[WORD_W-1:0])));

    // R5: the increment changes only through an executed load-increment.
    a_r5_inc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_exec && cmd_i == CMD_LOAD_INC) |=> $stable(inc_q));

    // R9: an applied armed step disarms itself.
    a_r9_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
        fire_now |=> !armed_q);

endmodule

// File: rtl/tod_snapshot.sv
// Module: tod_snapshot
// Captures the whole time value on a read command, one register per word,
// so all words come from the same edge. Assumes time_i is a registered value.
module tod_snapshot #(
    parameter int WORD_W = 32,
    parameter int NWORDS = 3,
    localparam int TIME_W = NWORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [TIME_W-1:0] time_i,
    output logic [TIME_W-1:0] snap_o
);

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;

        // Captures this word of the time value on a read edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (cap_en) begin
                word_q <= time_i[g*WORD_W +: WORD_W];
            end
        end

        assign snap_o[g*WORD_W +: WORD_W] = word_q;
    end

    // R7: a read edge captures the time present before that edge.
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (snap_o == $past(time_i)));

    // R7: without a read edge the snapshot holds its value.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(snap_o));

endmodule

// File: rtl/tod_sync_counter.sv
// Module: tod_sync_counter (top)
// Shadowed 96-bit time-of-day counter with two-phase command execution.
// Connects the shadow registers, the time core and the snapshot. Assumes
// sync_exec is shared by every instance that must switch together.
module tod_sync_counter
    import tod_pkg::*;
#(
    parameter int WORD_W       = 32,
    parameter int INC_HI_W     = 8,
    parameter int INC_RESET_NS = 1,
    localparam int INC_W  = WORD_W + INC_HI_W,
    localparam int TIME_W = 3 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sync_exec,
    output logic [TIME_W-1:0] time_o,
    output logic [TIME_W-1:0] snap_o,
    output logic [INC_W-1:0]  inc_o
);

    logic [WORD_W-1:0] sh_time_lo, sh_time_hi, sh_adj_lo, sh_adj_hi;
    tod_cmd_e          cmd;
    logic              cap_en;

    assign cap_en = sync_exec && (cmd == CMD_READ);

    tod_shadow_regs #(.WORD_W(WORD_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .sync_exec  (sync_exec),
        .sh_time_lo (sh_time_lo),
        .sh_time_hi (sh_time_hi),
        .sh_adj_lo  (sh_adj_lo),
        .sh_adj_hi  (sh_adj_hi),
        .cmd_o      (cmd)
    );

    tod_time_core #(
        .WORD_W       (WORD_W),
        .INC_HI_W     (INC_HI_W),
        .INC_RESET_NS (INC_RESET_NS)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_exec  (sync_exec),
        .cmd_i      (cmd),
        .sh_time_lo (sh_time_lo),
        .sh_time_hi (sh_time_hi),
        .sh_adj_lo  (sh_adj_lo),
        .sh_adj_hi  (sh_adj_hi),
        .time_o     (time_o),
        .inc_o      (inc_o)
    );

    tod_snapshot #(.WORD_W(WORD_W), .NWORDS(3)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .time_i (time_o),
        .snap_o (snap_o)
    );

endmodule

// File: tb/tod_sync_counter_tb.sv
// Bench: drives the register port and sync strobe, and keeps an arithmetic
// reference of the counter built from the requirements. It compares every
// output on every falling edge.
module tod_sync_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        sync_exec = 1'b0;
    logic [95:0] time_o, snap_o;
    logic [39:0] inc_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    tod_sync_counter dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_exec(sync_exec),
        .time_o(time_o), .snap_o(snap_o), .inc_o(inc_o)
    );

    // Reference state.
    logic [95:0] m_time, m_snap, nt;
    logic [39:0] m_inc;
    logic [31:0] m_tlo, m_thi, m_alo, m_ahi, m_tgt, m_aadj;
    logic [2:0]  m_cmd, m_ex;
    logic        m_arm;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_time <= '0; m_snap <= '0; m_inc <= 40'h01_0000_0000;
            m_tlo <= '0; m_thi <= '0; m_alo <= '0; m_ahi <= '0;
            m_cmd <= 3'd0; m_arm <= 1'b0; m_tgt <= '0; m_aadj <= '0;
        end else begin
            m_ex = sync_exec ? m_cmd : 3'd0;
            nt = m_time + {56'b0, m_inc};
            if (m_ex == 3'd1) nt = {m_thi, m_tlo, 32'b0};
            if (m_ex == 3'd2) m_inc <= {m_ahi[7:0], m_alo};
            if (m_ex == 3'd3) nt = {m_time[95:32] + {{32{m_ahi[31]}}, m_ahi}, m_time[31:0]};
            if (m_ex == 3'd4) begin m_arm <= 1'b1; m_tgt <= m_tlo; m_aadj <= m_ahi; end
            if (m_ex == 3'd5) m_snap <= m_time;
            if (m_ex == 3'd0 && m_arm && m_time[63:32] >= m_tgt) begin
                nt = {m_time[95:32] + {{32{m_aadj[31]}}, m_aadj}, m_time[31:0]};
                m_arm <= 1'b0;
            end
            m_time <= nt;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_tlo <= wr_data;
                    3'd1: m_thi <= wr_data;
                    3'd2: m_alo <= wr_data;
                    3'd3: m_ahi <= wr_data;
                    default: ;
                endcase
            end
            if (wr_en && wr_addr == 3'd4)
                m_cmd <= (wr_data[2:0] <= 3'd5) ? wr_data[2:0] : 3'd0;
            else if (sync_exec)
                m_cmd <= 3'd0;
        end
    end

    // Per-cycle comparison of every output against the reference.
    always @(negedge clk) begin
        if (!done) begin
            n_cmp += 3;
            if (time_o !== m_time) begin
                n_bad++;
                $display("FAIL %s time: actual %h expected %h", cur_req, time_o, m_time);
            end
            if (snap_o !== m_snap) begin
                n_bad++;
                $display("FAIL %s snapshot: actual %h expected %h", cur_req, snap_o, m_snap);
            end
            if (inc_o !== m_inc) begin
                n_bad++;
                $display("FAIL %s increment: actual %h expected %h", cur_req, inc_o, m_inc);
            end
        end
    end

    task automatic put(input logic [2:0] a, input logic [31:0] d, input logic s);
        wr_en = 1'b1; wr_addr = a; wr_data = d; sync_exec = s;
        @(posedge clk); #1;
        wr_en = 1'b0; sync_exec = 1'b0;
    endtask

    task automatic strobe();
        sync_exec = 1'b1;
        @(posedge clk); #1;
        sync_exec = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic load_inc(input logic [39:0] v);
        put(3'd2, v[31:0], 1'b0);
        put(3'd3, {24'b0, v[39:32]}, 1'b0);
        put(3'd4, 32'd2, 1'b0);
        strobe();
    endtask

    task automatic load_time(input logic [31:0] hi, input logic [31:0] lo);
        put(3'd0, lo, 1'b0);
        put(3'd1, hi, 1'b0);
        put(3'd4, 32'd1, 1'b0);
        strobe();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog (%s): actual hung expected finished", cur_req);
        finish_run();
    end

    logic [39:0] incs [4] = '{40'hFF_FFFF_FFFF, 40'h00_0000_0001,
                              40'h03_C000_0001, 40'h00_8000_0000};
    logic [31:0] los  [3] = '{32'h0, 32'hFFFF_FFF0, 32'hFFFF_FFFF};
    logic [31:0] his  [3] = '{32'h0, 32'h1, 32'hFFFF_FFFF};
    logic [31:0] adjs [6] = '{32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFB,
                              32'h7FFF_FFFF, 32'h8000_0000, 32'd0};

    initial begin
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        cur_req = "R2";
        idle(20);
        // R3: staged command and stray writes change nothing before sync.
        cur_req = "R3";
        put(3'd2, 32'h8000_0000, 1'b0);
        put(3'd3, 32'h0, 1'b0);
        put(3'd4, 32'd2, 1'b0);
        put(3'd6, 32'hDEAD_BEEF, 1'b0);
        idle(4);
        cur_req = "R5";
        strobe();
        idle(6);
        cur_req = "R3";
        put(3'd4, 32'd7, 1'b0);
        strobe();
        idle(3);
        // R2: sweep of increments, including full fraction carry.
        for (int i = 0; i < 4; i++) begin
            cur_req = "R5";
            load_inc(incs[i]);
            cur_req = "R2";
            idle(8);
        end
        // R4: load-time sweep over carry and wrap boundaries.
        for (int h = 0; h < 3; h++) begin
            for (int l = 0; l < 3; l++) begin
                cur_req = "R4";
                load_time(his[h], los[l]);
                idle(3);
            end
        end
        load_inc(40'h01_0000_0000);
        // R6: signed adjust sweep, including borrow from the high word.
        for (int a = 0; a < 6; a++) begin
            cur_req = "R6";
            load_time(32'd2, (a % 2 == 0) ? 32'd0 : 32'd3);
            put(3'd3, adjs[a], 1'b0);
            put(3'd4, 32'd3, 1'b0);
            strobe();
            idle(2);
        end
        // R7 and R8: read, then repeated strobes with nothing pending.
        for (int r = 0; r < 3; r++) begin
            cur_req = "R7";
            put(3'd4, 32'd5, 1'b0);
            idle(r);
            strobe();
            idle(2);
            cur_req = "R8";
            strobe();
            strobe();
            idle(2);
        end
        // R9: armed steps, positive and negative.
        cur_req = "R9";
        load_time(32'd0, 32'd100);
        put(3'd0, 32'd130, 1'b0);
        put(3'd3, 32'd1000, 1'b0);
        put(3'd4, 32'd4, 1'b0);
        strobe();
        idle(40);
        put(3'd0, 32'd1200, 1'b0);
        put(3'd3, 32'hFFFF_FF00, 1'b0);
        put(3'd4, 32'd4, 1'b0);
        strobe();
        idle(60);
        // R10: shadow write coinciding with the executing adjust.
        cur_req = "R10";
        put(3'd3, 32'd50, 1'b0);
        put(3'd4, 32'd3, 1'b0);
        put(3'd3, 32'd9, 1'b1);
        idle(2);
        put(3'd4, 32'd3, 1'b0);
        strobe();
        idle(2);
        // R11: armed step already due, read executes first, step follows.
        cur_req = "R11";
        put(3'd0, 32'd0, 1'b0);
        put(3'd3, 32'd500, 1'b0);
        put(3'd4, 32'd4, 1'b0);
        put(3'd4, 32'd5, 1'b1);
        strobe();
        idle(4);
        finish_run();
    end

endmodule